// File: doc/BRIEF.md
# Register-Mapped PWM Timer Channel

This block generates one active-high pulse-width-modulated output. Software sets it up through two 32-bit registers on a simple bus with write enable, read enable, address, write data and read data. One register carries the run switch, a hold flag and a division exponent. The other carries the period length and the high-time length, both counted in divided clocks. The divided clock is the input clock slowed by a power of two, with an exponent of up to 24.

Bus writes land in shadow registers. An active copy drives the counters. The active copy reloads from the shadows when the channel is stopped, or at the end of a period while it runs, and never while the hold flag is set. Software sets hold, rewrites the counts and the divider, and then clears hold. The output then changes to the complete new setting at one period boundary and never shows a mixture of old and new values.

The output cannot show a 0% duty cycle. If either active count is zero, the channel does not run.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, both registers read as zero and the output is low.
- R2: The division exponent is twice the 4-bit field at control bits 19:16 plus control bit 15, which is the least significant bit. The period and phase counters advance once every 2^exponent input clocks. An exponent above the parameter DIV_MAX (default 24) is treated as DIV_MAX.
- R3: With a period count P and a high count H, where H < P, the output is high for H·2^d input clocks, then low for (P−H)·2^d input clocks, and this repeats.
- R4: While running, the output is high at the start of every period. With H ≥ P, the output stays high permanently.
- R5: The channel stays stopped, with the output low, while either the active period count or the active high count is zero, even when control bit 0 (run) is set.
- R6: While control bit 11 (hold) is set, the active period, high count and exponent do not change. After hold clears, the shadow values take effect together at the next period boundary.
- R7: When run is cleared, the output goes low on the next clock. When run is set again, a fresh period starts with the output high.
- R8: The control register is at offset 0x00: run at bit 0, a stored clock-source bit at bit 4, hold at bit 11, the exponent LSB at bit 15, and the exponent field at bits 19:16. The count register is at offset 0x04: period at bits 25:16 and high count at bits 9:0. Read data appears the clock after read enable and shows the shadow contents. Undefined bits read as zero. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after rd_en |
| pwm_o | output | 1 | PWM output, active high |

## Verification
The assertions assume that the bus inputs are driven to known values whenever a strobe is high. They also assume that reset is released only while the strobes are low. The bench drives every input at the falling edge, holds each strobe for exactly one cycle, and makes one access per transaction. As a result, every register update is captured at one well-defined rising edge. Waveform checks only begin at an observed rising edge of the output, so the cycle in which the channel started has no effect on the measured high and low times.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    // fixed register layout
    localparam int CNT_W     = 10;
    localparam int OFS_CTRL  = 0;
    localparam int OFS_COUNT = 4;

    localparam int B_RUN     = 0;
    localparam int B_SRC     = 4;
    localparam int B_HOLD    = 11;
    localparam int B_DLSB    = 15;
    localparam int B_DHI     = 16;
    localparam int DHI_W     = 4;

    localparam int B_PER     = 16;
    localparam int B_HIGH    = 0;

    typedef struct packed {
        logic             run_en;
        logic             src_sel;
        logic             hold;
        logic             div_lsb;
        logic [DHI_W-1:0] div_hi;
    } ctrl_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  sh_per,
    output logic [CNT_W-1:0]  sh_high,
    output logic [31:0]       rdata
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] high;
        logic [31:0]      rdata;
    } regs_t;

    regs_t s_d, s_q;
    logic  sel_ctrl, sel_cnt;
    logic  unused_wdata;

    assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
    assign sel_cnt  = (addr == ADDR_W'(OFS_COUNT));

    assign unused_wdata = ^{wdata[31:26], wdata[15:12], wdata[10:5], wdata[3:1]};

    always_comb begin
        logic [31:0] rd;
        s_d = s_q;
        if (wr_en && sel_ctrl) begin
            s_d.ctrl.run_en  = wdata[B_RUN];
            s_d.ctrl.src_sel = wdata[B_SRC];
            s_d.ctrl.hold    = wdata[B_HOLD];
            s_d.ctrl.div_lsb = wdata[B_DLSB];
            s_d.ctrl.div_hi  = wdata[B_DHI +: DHI_W];
        end
        if (wr_en && sel_cnt) begin
            s_d.per  = wdata[B_PER  +: CNT_W];
            s_d.high = wdata[B_HIGH +: CNT_W];
        end
        rd = '0;
        if (sel_ctrl) begin
            rd[B_RUN]            = s_q.ctrl.run_en;
            rd[B_SRC]            = s_q.ctrl.src_sel;
            rd[B_HOLD]           = s_q.ctrl.hold;
            rd[B_DLSB]           = s_q.ctrl.div_lsb;
            rd[B_DHI +: DHI_W]   = s_q.ctrl.div_hi;
        end else if (sel_cnt) begin
            rd[B_PER  +: CNT_W]  = s_q.per;
            rd[B_HIGH +: CNT_W]  = s_q.high;
        end
        if (rd_en) begin
            s_d.rdata = rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl    = s_q.ctrl;
    assign sh_per  = s_q.per;
    assign sh_high = s_q.high;
    assign rdata   = s_q.rdata;
endmodule

// File: rtl/pwm_timer_prescale.sv
module pwm_timer_prescale #(
    parameter int DIV_MAX = 24,
    parameter int DIV_W   = $clog2(DIV_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PRE_W = DIV_MAX;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t             s_d, s_q;
    logic [PRE_W-1:0] lim;

    // low 'div' bits set: terminal count of the divider
    assign lim  = ~({PRE_W{1'b1}} << div);
    assign tick = (s_q.cnt == lim);

    always_comb begin
        s_d = s_q;
        if (clr || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
    import pwm_timer_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold,
    input  logic [CNT_W-1:0] sh_per,
    input  logic [CNT_W-1:0] sh_high,
    input  logic [DIV_W-1:0] sh_div,
    input  logic             tick,
    output logic             run,
    output logic [CNT_W-1:0] ph,
    output logic [CNT_W-1:0] act_per,
    output logic [CNT_W-1:0] act_high,
    output logic [DIV_W-1:0] act_div,
    output logic             pwm
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] ph;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] high;
        logic [DIV_W-1:0] div;
    } core_t;

    core_t s_d, s_q;
    logic  last, boundary, load;

    assign last     = (s_q.ph == s_q.per - 1'b1);
    assign boundary = s_q.run && tick && last;
    assign load     = !hold && (!s_q.run || boundary);

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.per  = sh_per;
            s_d.high = sh_high;
            s_d.div  = sh_div;
        end
        s_d.run = en && (s_d.per != '0) && (s_d.high != '0);
        if (!s_d.run || !s_q.run || boundary) begin
            s_d.ph = '0;
        end else if (tick) begin
            s_d.ph = s_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run      = s_q.run;
    assign ph       = s_q.ph;
    assign act_per  = s_q.per;
    assign act_high = s_q.high;
    assign act_div  = s_q.div;
    assign pwm      = s_q.run && (s_q.ph < s_q.high);
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DIV_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              pwm_o
);
    localparam int DIV_W = $clog2(DIV_MAX + 1);
    localparam int RAW_W = DHI_W + 1;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] sh_per, sh_high;
    logic [RAW_W-1:0] raw_div;
    logic [DIV_W-1:0] sh_div;
    logic             en_sh, hold_sh;
    logic             tick, run_q;
    logic [CNT_W-1:0] ph_q, act_per, act_high;
    logic [DIV_W-1:0] act_div;

    pwm_timer_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .ctrl    (ctrl),
        .sh_per  (sh_per),
        .sh_high (sh_high),
        .rdata   (rdata)
    );

    // exponent = 2*field + lsb, saturated at DIV_MAX
    assign raw_div = {ctrl.div_hi, ctrl.div_lsb};
    assign sh_div  = (int'(raw_div) > DIV_MAX) ? DIV_W'(DIV_MAX) : DIV_W'(raw_div);
    assign en_sh   = ctrl.run_en;
    assign hold_sh = ctrl.hold;

    pwm_timer_prescale #(.DIV_MAX(DIV_MAX), .DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!run_q),
        .div   (act_div),
        .tick  (tick)
    );

    pwm_timer_core #(.DIV_W(DIV_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_sh),
        .hold     (hold_sh),
        .sh_per   (sh_per),
        .sh_high  (sh_high),
        .sh_div   (sh_div),
        .tick     (tick),
        .run      (run_q),
        .ph       (ph_q),
        .act_per  (act_per),
        .act_high (act_high),
        .act_div  (act_div),
        .pwm      (pwm_o)
    );
endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk
    import pwm_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              hold,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              pwm,
    input logic              run,
    input logic [CNT_W-1:0]  ph,
    input logic [CNT_W-1:0]  per,
    input logic [CNT_W-1:0]  high,
    input logic [DIV_W-1:0]  div
);
    a_r7_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm);

    a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> pwm);

    a_r5_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        pwm |-> (per != '0) && (high != '0));

    a_r6_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(per) && $stable(high) && $stable(div));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr != ADDR_W'(OFS_CTRL)) && (addr != ADDR_W'(OFS_COUNT)) |=> rdata == '0);

    a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ph < per);
endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_sh),
    .hold  (hold_sh),
    .rd_en (rd_en),
    .addr  (addr),
    .rdata (rdata),
    .pwm   (pwm_o),
    .run   (run_q),
    .ph    (ph_q),
    .per   (act_per),
    .high  (act_high),
    .div   (act_div)
);

// File: tb/pwm_timer_chan_bench.sv
module pwm_timer_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_a = 1'b0, wr_b = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        pwm_a, pwm_b;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_timer_chan u_pwm_timer_chan (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_a), .pwm_o(pwm_a)
    );

    // second copy with a small exponent ceiling for the saturation check
    pwm_timer_chan #(.DIV_MAX(3)) u_pwm_small (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .rd_en(1'b0), .addr(addr),
        .wdata(wdata), .rdata(rdata_b), .pwm_o(pwm_b)
    );

    function automatic logic pw(input bit b);
        return b ? pwm_b : pwm_a;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (b) wr_b = 1'b1; else wr_a = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata_a;
    endtask

    // length of one full high and low stretch, starting at a rising edge
    task automatic measure(input bit b, output int hi, output int lo);
        int guard = 0;
        hi = 0;
        lo = 0;
        while (pw(b) == 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
        while (pw(b) == 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        while (pw(b) == 1'b1 && guard < 4000) begin hi++; @(negedge clk); guard++; end
        while (pw(b) == 1'b0 && guard < 4000) begin lo++; @(negedge clk); guard++; end
    endtask

    task automatic setup(input bit b, input logic [31:0] cnt, input logic [31:0] ctl);
        wr(b, 8'h00, 32'h0);
        wr(b, 8'h04, cnt);
        wr(b, 8'h00, ctl);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 output low", int'(pwm_a), 0);
        rd(8'h00, d);
        chk32("R1 control reads zero", d, 32'h0);
        rd(8'h04, d);
        chk32("R1 count reads zero", d, 32'h0);
    endtask

    task automatic t_basic;
        int hi, lo;
        setup(1'b0, 32'h0005_0002, 32'h0000_0001);
        measure(1'b0, hi, lo);
        chk("R3 high time P5 H2", hi, 2);
        chk("R3 low time P5 H2", lo, 3);
    endtask

    task automatic t_divide;
        int hi, lo;
        setup(1'b0, 32'h0003_0002, 32'h0001_0001);   // exponent 2
        measure(1'b0, hi, lo);
        chk("R2 exp2 high", hi, 8);
        chk("R2 exp2 low", lo, 4);
        setup(1'b0, 32'h0004_0001, 32'h0001_8001);   // exponent 3
        measure(1'b0, hi, lo);
        chk("R2 exp3 high", hi, 8);
        chk("R2 exp3 low", lo, 24);
    endtask

    task automatic t_clamp;
        int hi, lo;
        setup(1'b1, 32'h0002_0001, 32'h0002_8001);   // exponent 5 -> 3
        measure(1'b1, hi, lo);
        chk("R2 saturated high", hi, 8);
        chk("R2 saturated low", lo, 8);
    endtask

    task automatic t_full;
        int highs = 0;
        setup(1'b0, 32'h0003_0003, 32'h0000_0001);
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            if (pwm_a) highs++;
            @(negedge clk);
        end
        chk("R4 H equal P stays high", highs, 30);
    endtask

    task automatic t_refuse;
        int highs = 0;
        setup(1'b0, 32'h0005_0000, 32'h0000_0001);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_a) highs++;
        end
        chk("R5 zero high count", highs, 0);
        highs = 0;
        setup(1'b0, 32'h0000_0003, 32'h0000_0001);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_a) highs++;
        end
        chk("R5 zero period count", highs, 0);
    endtask

    task automatic t_hold;
        int hi, lo;
        setup(1'b0, 32'h0005_0002, 32'h0000_0001);
        wr(1'b0, 8'h00, 32'h0000_0801);
        wr(1'b0, 8'h04, 32'h0008_0006);
        measure(1'b0, hi, lo);
        chk("R6 held high", hi, 2);
        chk("R6 held low", lo, 3);
        wr(1'b0, 8'h00, 32'h0000_0001);
        measure(1'b0, hi, lo);
        chk("R6 released high", hi, 6);
        chk("R6 released low", lo, 2);
    endtask

    task automatic t_stop;
        int highs = 0;
        setup(1'b0, 32'h0005_0002, 32'h0000_0001);
        repeat (3) @(negedge clk);
        wr(1'b0, 8'h00, 32'h0);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (pwm_a) highs++;
            @(negedge clk);
        end
        chk("R7 low after stop", highs, 0);
        wr(1'b0, 8'h00, 32'h0000_0001);
        @(negedge clk);
        chk("R7 restart high", int'(pwm_a), 1);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(1'b0, 8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d);
        chk32("R8 control bits", d, 32'h000F_8811);
        wr(1'b0, 8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d);
        chk32("R8 count bits", d, 32'h03FF_03FF);
        wr(1'b0, 8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d);
        chk32("R8 unmapped reads zero", d, 32'h0);
        wr(1'b0, 8'h00, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_divide();
        t_clamp();
        t_full();
        t_refuse();
        t_hold();
        t_stop();
        t_map();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule